// File: doc/BRIEF.md
# Dithered High-Resolution PWM Generator

This block drives a single-bit pulse-width-modulated output with a fixed period of 256 clocks and a resolution of one clock. Each period has one pulse. The pulse starts on clock 0 of the period, and its length comes from an 8-bit width. A separate full-high flag lets a period stay high for all 256 clocks, which is a width of 256.

To give finer resolution than 8 bits, the block takes a 16-bit level and dithers it:

- The upper byte of the level is the base width of a period.
- The lower byte is added to an 8-bit phase accumulator once per period.
- Each carry out of that addition lengthens the pulse by one clock.
- Over 16 periods, the total high time therefore tracks the upper 12 bits of the level.

A ramp mode holds an internal copy of the level. It raises that copy by 16 every 16 periods, which gives a slow sawtooth without any input activity.

The level is sampled once per period, on the clock marked by the period-start strobe. A sampled value first takes effect in the following period, so a period in progress is never disturbed. The width being applied is visible on `width_now` and `full_now`.

Top module: `dpwm_top`

## Requirements
- R1: The counter runs a period of exactly 256 clocks. `period_start` is high for one clock, on clock 0 of every period, and low on the other 255.
- R2: With an active width w and `full_now` = 0, `pwm_out` is high on clocks 0 to w-1 of the period and low on the rest. A width of 0 keeps the output low for all 256 clocks.
- R3: When `full_now` is 1, `pwm_out` is high on all 256 clocks of the period, and `width_now` reads 0.
- R4: `level_in` and `ramp_en` are sampled only on the rising edge that ends clock 0 of a period. The value sampled there sets the width of the next period. A change on the inputs at any other clock has no effect.
- R5: `width_now` and `full_now` change only at the boundary into clock 0, and they stay constant for the whole period.
- R6: For a sampled level L, the next width is L[15:8]. L[7:0] is added to the 8-bit phase accumulator, and a carry out of bit 7 adds one to that width.
- R7: When L[15:8] is 255 and the addition carries, the next period is full-high: `full_now` = 1 and `width_now` = 0.
- R8: Over any 16 consecutive periods that were all sampled from the same level L, the total high clocks equal L[15:4] within one count.
- R9: While `ramp_en` is sampled high, `level_in` is ignored and an internal level is used instead. Each value of the internal level is used for 16 consecutive samplings. After the 16th, it is increased by 0x10, with carry into the upper byte, wrapping at 16 bits. The internal level holds the last sampled `level_in` from the last sampling with `ramp_en` low.
- R10: A synchronous reset clears the following state: the accumulator, the internal level, the ramp count, the buffered width and the active width. During reset, and through the whole first period after it, `pwm_out` is low. The first clock after reset is clock 0 of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| level_in | input | 16 | Level: upper byte is the base width, lower byte is the dither fraction |
| ramp_en | input | 1 | Selects the self-incrementing internal level |
| pwm_out | output | 1 | PWM output |
| period_start | output | 1 | One-clock strobe on clock 0 of each period |
| width_now | output | 8 | Width applied in the current period |
| full_now | output | 1 | Current period is full-high (width 256) |

## Verification
A level sampled at the clock-0 edge shows up one full period later. It appears on `width_now` at clock 0 of the next period, 256 clocks after it was sampled. `pwm_out` and `period_start` follow the period counter with no extra register stage, so clock k of a period is seen in the k-th cycle after the strobe. The bench therefore walks each period on falling edges, starting with the one where the strobe is high. It compares every one of the 256 samples against a model that is one period behind the inputs. Inputs are changed only on falling edges: at clock 0 for a new level, and halfway through the period to show that a mid-period change is ignored.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  // default geometry of the generator
  localparam int unsigned DPWM_CNT_W    = 8;   // period = 2**CNT_W clocks
  localparam int unsigned DPWM_LVL_W    = 16;  // level = width byte + fraction byte
  localparam int unsigned DPWM_RAMP_LEN = 16;  // periods per ramp step
  localparam int unsigned DPWM_RAMP_INC = 16;  // ramp step added to the level
endpackage

// File: rtl/dpwm_period_ctr.sv
module dpwm_period_ctr #(
  parameter int unsigned CNT_W = dpwm_pkg::DPWM_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign start_o = (cnt_q == '0);
  assign last_o  = (cnt_q == '1);

  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
  // R1
  period_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    last_o |=> start_o);
endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither #(
  parameter int unsigned CNT_W    = dpwm_pkg::DPWM_CNT_W,
  parameter int unsigned LVL_W    = dpwm_pkg::DPWM_LVL_W,
  parameter int unsigned RAMP_LEN = dpwm_pkg::DPWM_RAMP_LEN,
  parameter int unsigned RAMP_INC = dpwm_pkg::DPWM_RAMP_INC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             ramp_i,
  output logic [CNT_W-1:0] nxt_w_o,
  output logic             nxt_full_o
);
  localparam int unsigned FRAC_W = LVL_W - CNT_W;
  localparam int unsigned GRP_W  = (RAMP_LEN > 1) ? $clog2(RAMP_LEN) : 1;
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(RAMP_LEN - 1);
  localparam logic [LVL_W-1:0] STEP     = LVL_W'(RAMP_INC);

  logic [FRAC_W-1:0] acc_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [GRP_W-1:0]  grp_q;
  logic [CNT_W-1:0]  nxt_w_q;
  logic              nxt_full_q;

  logic [LVL_W-1:0]  src;
  logic [FRAC_W:0]   frac_sum;
  logic              carry;
  logic [CNT_W:0]    base_inc;
  logic              ramp_wrap;

  // level source: live input, or the self-stepping copy in ramp mode
  assign src       = ramp_i ? lvl_q : level_i;
  assign frac_sum  = {1'b0, acc_q} + {1'b0, src[FRAC_W-1:0]};
  assign carry     = frac_sum[FRAC_W];
  assign base_inc  = {1'b0, src[LVL_W-1:FRAC_W]} + {{CNT_W{1'b0}}, carry};
  assign ramp_wrap = ramp_i && (grp_q == GRP_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      lvl_q      <= '0;
      grp_q      <= '0;
      nxt_w_q    <= '0;
      nxt_full_q <= 1'b0;
    end else if (strobe_i) begin
      acc_q      <= frac_sum[FRAC_W-1:0];
      nxt_w_q    <= base_inc[CNT_W-1:0];
      nxt_full_q <= base_inc[CNT_W];
      lvl_q      <= ramp_wrap ? src + STEP : src;
      if (!ramp_i || ramp_wrap) grp_q <= '0;
      else                      grp_q <= grp_q + 1'b1;
    end
  end

  assign nxt_w_o    = nxt_w_q;
  assign nxt_full_o = nxt_full_q;

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> $stable(acc_q));
  // R6
  zero_frac_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && !ramp_i && (level_i[FRAC_W-1:0] == '0)) |=>
      (nxt_w_q == $past(level_i[LVL_W-1:FRAC_W])) && !nxt_full_q);
  // R9
  ramp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && ramp_i && (grp_q != GRP_LAST)) |=> (lvl_q == $past(lvl_q)));
endmodule

// File: rtl/dpwm_out_stage.sv
module dpwm_out_stage #(
  parameter int unsigned CNT_W = dpwm_pkg::DPWM_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] nxt_w_i,
  input  logic             nxt_full_i,
  output logic [CNT_W-1:0] width_o,
  output logic             full_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] width_q;
  logic             full_q;

  // second buffer stage: copied only on the last clock of a period
  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= '0;
      full_q  <= 1'b0;
    end else if (load_i) begin
      width_q <= nxt_w_i;
      full_q  <= nxt_full_i;
    end
  end

  assign pwm_o   = full_q | (cnt_i < width_q);
  assign width_o = width_q;
  assign full_o  = full_q;

  // R5
  width_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_i != '0) |-> ($stable(width_q) && $stable(full_q)));
  // R2
  rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_o && (cnt_i != '0)) |-> $past(pwm_o));
endmodule

// File: rtl/dpwm_top.sv
module dpwm_top #(
  parameter int unsigned CNT_W    = dpwm_pkg::DPWM_CNT_W,
  parameter int unsigned LVL_W    = dpwm_pkg::DPWM_LVL_W,
  parameter int unsigned RAMP_LEN = dpwm_pkg::DPWM_RAMP_LEN,
  parameter int unsigned RAMP_INC = dpwm_pkg::DPWM_RAMP_INC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level_in,
  input  logic             ramp_en,
  output logic             pwm_out,
  output logic             period_start,
  output logic [CNT_W-1:0] width_now,
  output logic             full_now
);
  logic [CNT_W-1:0] cnt;
  logic             start;
  logic             last;
  logic [CNT_W-1:0] nxt_w;
  logic             nxt_full;

  dpwm_period_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst(rst), .cnt_o(cnt), .start_o(start), .last_o(last)
  );

  dpwm_dither #(
    .CNT_W(CNT_W), .LVL_W(LVL_W), .RAMP_LEN(RAMP_LEN), .RAMP_INC(RAMP_INC)
  ) dith_i (
    .clk(clk), .rst(rst), .strobe_i(start), .level_i(level_in),
    .ramp_i(ramp_en), .nxt_w_o(nxt_w), .nxt_full_o(nxt_full)
  );

  dpwm_out_stage #(.CNT_W(CNT_W)) out_i (
    .clk(clk), .rst(rst), .cnt_i(cnt), .load_i(last),
    .nxt_w_i(nxt_w), .nxt_full_i(nxt_full),
    .width_o(width_now), .full_o(full_now), .pwm_o(pwm_out)
  );

  assign period_start = start;

  // R10
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (!pwm_out && !full_now && (width_now == '0)));
endmodule

// File: tb/dpwm_top_tb_top.sv
`timescale 1ns/1ps
module dpwm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] level_in = 16'h0000;
  logic        ramp_en = 1'b0;
  logic        pwm_out, period_start, full_now;
  logic [7:0]  width_now;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // reference model state (one period behind the inputs)
  logic [7:0]  m_acc = 8'h00;
  logic [15:0] m_lvl = 16'h0000;
  int          m_grp = 0;
  logic [7:0]  cur_w = 8'h00;
  logic        cur_f = 1'b0;
  int          last_highs = 0;

  always #2 clk = ~clk;

  dpwm_top dut_i (
    .clk(clk), .rst(rst), .level_in(level_in), .ramp_en(ramp_en),
    .pwm_out(pwm_out), .period_start(period_start),
    .width_now(width_now), .full_now(full_now)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Called on the falling edge of clock 0; walks one whole period.
  task automatic run_period(input logic [15:0] lvl, input logic ramp,
                            input logic [15:0] mid, input string req);
    logic [15:0] src;
    logic [8:0]  s;
    logic [8:0]  ws;
    int highs = 0, strobes = 0, bad = 0, wchg = 0;
    logic [7:0] w0;
    logic f0;
    level_in = lvl;
    ramp_en  = ramp;
    src = ramp ? m_lvl : lvl;
    s   = {1'b0, m_acc} + {1'b0, src[7:0]};
    ws  = {1'b0, src[15:8]} + {8'h00, s[8]};
    m_acc = s[7:0];
    m_lvl = (ramp && m_grp == 15) ? src + 16'h0010 : src;
    m_grp = (ramp && m_grp != 15) ? m_grp + 1 : 0;
    w0 = width_now;
    f0 = full_now;
    chk(width_now == cur_w, "R5", "width_now at clock 0", width_now, cur_w);
    chk(full_now == cur_f, "R3", "full_now at clock 0", full_now, cur_f);
    for (int i = 0; i < 256; i++) begin
      if (period_start) strobes++;
      if (i == 0 && !period_start) bad += 1000;
      if (pwm_out) highs++;
      if (pwm_out != (cur_f | (i < cur_w))) bad++;
      if (width_now != w0 || full_now != f0) wchg++;
      if (i == 128) level_in = mid;
      @(negedge clk);
    end
    chk(strobes == 1 && bad < 1000, "R1", "strobes per period", strobes, 1);
    chk(bad == 0, req, "pwm samples wrong in period", bad, 0);
    chk(highs == (cur_f ? 256 : int'(cur_w)), req, "high clocks", highs,
        cur_f ? 256 : int'(cur_w));
    chk(wchg == 0, "R5", "width changes inside period", wchg, 0);
    last_highs = highs;
    cur_w = ws[7:0];
    cur_f = ws[8];
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk(pwm_out == 1'b0, "R10", "pwm_out in reset", pwm_out, 0);
    chk(width_now == 8'h00 && full_now == 1'b0, "R10", "active width in reset",
        width_now, 0);
    level_in = 16'h8000;
    rst = 1'b0;
    chk(period_start == 1'b1, "R10", "strobe on first clock after reset",
        period_start, 1);
    run_period(16'h8000, 1'b0, 16'h8000, "R10");
    chk(last_highs == 0, "R10", "first period high clocks", last_highs, 0);
  endtask

  task automatic t_widths();
    // R2 / R4: mid-period level changes must be ignored
    run_period(16'h0000, 1'b0, 16'h5500, "R4");
    run_period(16'h0100, 1'b0, 16'hAA00, "R2");
    run_period(16'hFF00, 1'b0, 16'h0300, "R4");
    run_period(16'h0000, 1'b0, 16'h7700, "R2");
    chk(last_highs == 255, "R2", "width 255 high clocks", last_highs, 255);
    run_period(16'h2A00, 1'b0, 16'h2A00, "R2");
    chk(last_highs == 0, "R2", "width 0 high clocks", last_highs, 0);
    run_period(16'h2A00, 1'b0, 16'h2A00, "R2");
    chk(last_highs == 42, "R2", "width 42 high clocks", last_highs, 42);
  endtask

  task automatic t_window(input logic [15:0] lvl, input bool_full);
    int sum = 0, fulls = 0;
    int tgt = int'(lvl[15:4]);
    for (int j = 0; j < 17; j++) begin
      run_period(lvl, 1'b0, ~lvl, "R6");
      if (j > 0) begin
        sum += last_highs;
        if (last_highs == 256) fulls++;
      end
    end
    chk(sum >= tgt - 1 && sum <= tgt + 1, "R8", "16-period high total", sum, tgt);
    if (bool_full)
      chk(fulls > 0, "R7", "full-high periods in window", fulls, 8);
  endtask

  task automatic t_ramp();
    int steps = 0;
    run_period(16'h2070, 1'b0, 16'h2070, "R9");
    for (int j = 0; j < 36; j++) begin
      run_period(16'hDEAD, 1'b1, 16'h1234, "R9");
    end
    run_period(16'h0500, 1'b0, 16'h0500, "R9");
    // the internal level has advanced by two steps: 0x2070 -> 0x2090
    chk(m_lvl == 16'h0500, "R9", "model level reload", m_lvl, 16'h0500);
    run_period(16'h0500, 1'b0, 16'h0500, "R9");
    chk(last_highs == 5, "R9", "input level after ramp off", last_highs, 5);
    steps = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        checks++;
        fails++;
        $display("FAIL R1 watchdog: cycles=%0d expected<150000", cyc);
        summary();
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_widths();
    t_window(16'h3A7C, 1'b0);
    t_window(16'hFF80, 1'b1);
    t_ramp();
    done = 1;
    summary();
    $finish;
  end
endmodule